// File: doc/BRIEF.md
# SPI Serial NOR Flash Device Model

This block acts as the device side of a four-wire SPI bus and looks to a bus master like a small serial NOR flash. It runs on a fast system clock and oversamples the bus pins through two-flop synchronizers. This makes the serial clock an ordinary data input, so the whole block is a single synchronous clock domain. Behind the bus sits a byte-wide RAM array, 4 KB by default. The array is divided into 256-byte pages and 1 KB sectors and starts out fully erased (every byte FFh).

The block decodes five single-line commands:
- write-enable latch set (06h)
- status read (05h)
- normal read (03h)
- page program (02h)
- sector erase (20h)

Program data first goes into a page staging buffer. The commit to the array starts only when select is released. A program or erase runs as an internal sweep of the array. That sweep sits inside a busy window of fixed length, and status bit 0 reports the window. Both bus modes are accepted: clock idling low and clock idling high. Data in is sampled on rising clock edges, and data out changes after falling edges.

Top module: `spi_flash_model`

## Requirements
- R1: After reset, spi_miso is 0 and the status register reads 00h.
- R2: A transaction works whether the serial clock idles low or idles high while select is high.
- R3: Opcode 06h sets the write-enable latch (status bit 1). It does so only when exactly one byte is sent before select rises; a longer transaction leaves the latch unchanged.
- R4: Opcode 05h returns the status byte {6'b0, latch, busy}. Busy is bit 0 and the latch is bit 1. The byte repeats for as long as select stays low.
- R5: Opcode 03h is followed by three address bytes, MSB first, of which the low address bits are used. Array bytes then stream out from that address, and the address wraps from the last byte of the array to 0.
- R6: Opcode 02h plus three address bytes plus data bytes programs the array. Each addressed byte becomes old value AND written value.
- R7: In a program burst, the byte address wraps within its own 256-byte page. Bytes in other pages are untouched.
- R8: Opcode 20h plus three address bytes sets every byte of the 1 KB sector that holds the address to FFh. Bytes in other sectors are untouched.
- R9: A program or erase with the write-enable latch clear changes neither the array nor the status.
- R10: A command whose select rises in the middle of a byte has no effect.
- R11: For BUSY_CYCLES system clocks after a program or erase starts, status reads 03h. Both bits then clear together. While busy, every command other than status read is ignored, and a read returns zero bytes.
- R12: spi_miso is 0 while select is high. While select is low, spi_miso changes only after a falling serial clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the bus master |
| spi_cs_n | input | 1 | Active-low device select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master (registered) |

## Verification
The hardest state to reach from the ports is a sector erase whose effect must be told apart from the neighbouring sectors. That needs known non-FF data sitting on both sides of both sector boundaries. The stimulus plants such bytes with four separate enable-and-program sequences, polling status after each one until busy clears. It then erases by an address in the middle of the sector and reads across both boundaries. The program-wrap and read-wrap cases are reached the same way, by planting bytes at the last address of a page and of the array before reading across the edge.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'h20;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_PRD,
    ENG_PWR,
    ENG_ERS,
    ENG_HOLD
  } eng_state_t;
endpackage

// File: rtl/sfm_sync.sv
module sfm_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sfm_ram.sv
module sfm_ram #(
  parameter int          AW   = 12,
  parameter int          DW   = 8,
  parameter logic [DW-1:0] INIT = '1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = INIT;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    rd <= mem[addr];
  end
endmodule

// File: rtl/sfm_spi_rx.sv
module sfm_spi_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck_s,
  input  logic       cs_n_s,
  input  logic       mosi_s,
  output logic       cs_act,
  output logic       cs_rise,
  output logic       sck_fall,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic [2:0] bit_cnt
);
  logic sck_d;
  logic cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d      <= 1'b0;
      cs_d       <= 1'b1;
      byte_data  <= '0;
      bit_cnt    <= '0;
      byte_valid <= 1'b0;
    end else begin
      sck_d      <= sck_s;
      cs_d       <= cs_n_s;
      byte_valid <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
      end else if (sck_s && !sck_d) begin
        byte_data <= {byte_data[6:0], mosi_s};
        bit_cnt   <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) byte_valid <= 1'b1;
      end
    end
  end

  assign cs_act   = !cs_d;
  assign cs_rise  = cs_n_s && !cs_d;
  assign sck_fall = !sck_s && sck_d && !cs_n_s;
endmodule

// File: rtl/sfm_engine.sv
module sfm_engine
  import sfm_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PAGE_W      = 8,
  parameter int SECT_W      = 10,
  parameter int BUSY_CYCLES = 1500
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_pp,
  input  logic                     start_se,
  input  logic [ADDR_W-PAGE_W-1:0] page_sel,
  input  logic [ADDR_W-SECT_W-1:0] sect_sel,
  input  logic [(1<<PAGE_W)-1:0]   pp_vld,
  input  logic [7:0]               mem_rd,
  input  logic [7:0]               buf_rd,
  output logic                     busy,
  output logic                     done,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic                     mem_we,
  output logic [7:0]               mem_wd,
  output logic [PAGE_W-1:0]        buf_addr
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  eng_state_t               state;
  logic [SECT_W-1:0]        idx;
  logic [CNT_W-1:0]         cnt;
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic [ADDR_W-SECT_W-1:0] sect_q;
  logic                     hold_end;

  assign busy     = (state != ENG_IDLE);
  assign hold_end = (cnt >= CNT_W'(BUSY_CYCLES - 1));
  assign done     = (state == ENG_HOLD) && hold_end;
  assign buf_addr = idx[PAGE_W-1:0];

  always_comb begin
    mem_we   = 1'b0;
    mem_wd   = 8'hFF;
    mem_addr = {page_q, idx[PAGE_W-1:0]};
    case (state)
      ENG_PWR: begin
        mem_we = pp_vld[idx[PAGE_W-1:0]];
        mem_wd = mem_rd & buf_rd;
      end
      ENG_ERS: begin
        mem_addr = {sect_q, idx};
        mem_we   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ENG_IDLE;
      idx    <= '0;
      cnt    <= '0;
      page_q <= '0;
      sect_q <= '0;
    end else begin
      if (busy && cnt != CNT_W'(BUSY_CYCLES)) cnt <= cnt + 1'b1;
      case (state)
        ENG_IDLE: begin
          idx <= '0;
          cnt <= '0;
          if (start_pp) begin
            page_q <= page_sel;
            state  <= ENG_PRD;
          end else if (start_se) begin
            sect_q <= sect_sel;
            state  <= ENG_ERS;
          end
        end
        ENG_PRD: state <= ENG_PWR;
        ENG_PWR: begin
          if (idx[PAGE_W-1:0] == '1) state <= ENG_HOLD;
          else begin
            idx   <= idx + 1'b1;
            state <= ENG_PRD;
          end
        end
        ENG_ERS: begin
          if (idx == '1) state <= ENG_HOLD;
          else idx <= idx + 1'b1;
        end
        ENG_HOLD: if (hold_end) state <= ENG_IDLE;
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_flash_model.sv
module spi_flash_model
  import sfm_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PAGE_W      = 8,
  parameter int SECT_W      = 10,
  parameter int BUSY_CYCLES = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic       sck_s, cs_n_s, mosi_s;
  logic       cs_act, cs_rise, sck_fall, byte_valid;
  logic [7:0] byte_data;
  logic [2:0] bit_cnt;

  sfm_sync #(.W(3), .RST_VAL(3'b010)) sync_i (
    .clk(clk), .rst(rst),
    .d({spi_sck, spi_cs_n, spi_mosi}),
    .q({sck_s, cs_n_s, mosi_s})
  );

  sfm_spi_rx rx_i (
    .clk(clk), .rst(rst), .sck_s(sck_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .cs_act(cs_act), .cs_rise(cs_rise), .sck_fall(sck_fall),
    .byte_valid(byte_valid), .byte_data(byte_data), .bit_cnt(bit_cnt)
  );

  logic                  wel, eng_busy, eng_done;
  logic [7:0]            opcode;
  logic                  cmd_ok;
  logic [2:0]            byte_cnt;
  logic [ADDR_W-1:0]     addr, rd_ptr, rd_addr_c;
  logic [PAGE_W-1:0]     pp_idx;
  logic                  pp_any;
  logic [PAGE_BYTES-1:0] vld;
  logic [7:0]            tx_sh;
  logic                  load_pend;
  logic                  miso_q;
  logic [7:0]            status;
  logic                  start_ok, start_pp, start_se;

  logic [ADDR_W-1:0] mem_addr, eng_mem_addr;
  logic              mem_we, eng_mem_we;
  logic [7:0]        mem_wd, eng_mem_wd, mem_rd;
  logic [PAGE_W-1:0] buf_addr, eng_buf_addr;
  logic              buf_we;
  logic [7:0]        buf_rd;

  assign status    = {6'b0, wel, eng_busy};
  assign rd_addr_c = (byte_cnt == 3'd3) ? ADDR_W'({addr, byte_data}) : rd_ptr;
  assign start_ok  = cs_rise && (bit_cnt == 3'd0) && !eng_busy && wel && cmd_ok;
  assign start_pp  = start_ok && (opcode == OP_PP) && pp_any;
  assign start_se  = start_ok && (opcode == OP_SE) && (byte_cnt == 3'd4);
  assign buf_we    = byte_valid && cs_act && cmd_ok && !eng_busy &&
                     (opcode == OP_PP) && (byte_cnt == 3'd4);
  assign buf_addr  = eng_busy ? eng_buf_addr : pp_idx;
  assign mem_addr  = eng_busy ? eng_mem_addr : rd_addr_c;
  assign mem_we    = eng_busy && eng_mem_we;
  assign mem_wd    = eng_mem_wd;
  assign spi_miso  = miso_q;

  sfm_ram #(.AW(ADDR_W), .DW(8), .INIT(8'hFF)) array_i (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wd(mem_wd), .rd(mem_rd)
  );

  sfm_ram #(.AW(PAGE_W), .DW(8), .INIT(8'hFF)) pbuf_i (
    .clk(clk), .we(buf_we), .addr(buf_addr), .wd(byte_data), .rd(buf_rd)
  );

  sfm_engine #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECT_W(SECT_W), .BUSY_CYCLES(BUSY_CYCLES)
  ) eng_i (
    .clk(clk), .rst(rst), .start_pp(start_pp), .start_se(start_se),
    .page_sel(addr[ADDR_W-1:PAGE_W]), .sect_sel(addr[ADDR_W-1:SECT_W]),
    .pp_vld(vld), .mem_rd(mem_rd), .buf_rd(buf_rd),
    .busy(eng_busy), .done(eng_done), .mem_addr(eng_mem_addr),
    .mem_we(eng_mem_we), .mem_wd(eng_mem_wd), .buf_addr(eng_buf_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wel       <= 1'b0;
      opcode    <= '0;
      cmd_ok    <= 1'b0;
      byte_cnt  <= '0;
      addr      <= '0;
      rd_ptr    <= '0;
      pp_idx    <= '0;
      pp_any    <= 1'b0;
      vld       <= '0;
      tx_sh     <= '0;
      load_pend <= 1'b0;
      miso_q    <= 1'b0;
    end else begin
      load_pend <= 1'b0;
      if (eng_done) wel <= 1'b0;
      if (cs_rise && bit_cnt == 3'd0 && !eng_busy &&
          opcode == OP_WREN && byte_cnt == 3'd1)
        wel <= 1'b1;
      if (!cs_act) begin
        byte_cnt <= '0;
        tx_sh    <= '0;
        miso_q   <= 1'b0;
        pp_any   <= 1'b0;
      end else begin
        if (sck_fall) begin
          miso_q <= tx_sh[7];
          tx_sh  <= {tx_sh[6:0], 1'b0};
        end
        if (load_pend) tx_sh <= mem_rd;
        if (byte_valid) begin
          if (byte_cnt != 3'd4) byte_cnt <= byte_cnt + 3'd1;
          if (byte_cnt == 3'd0) begin
            opcode <= byte_data;
            cmd_ok <= !eng_busy || (byte_data == OP_RDSR);
            if (byte_data == OP_RDSR) tx_sh <= status;
            if (byte_data == OP_PP && !eng_busy) vld <= '0;
          end else begin
            if (opcode == OP_RDSR) tx_sh <= status;
            if (byte_cnt != 3'd4) begin
              addr <= ADDR_W'({addr, byte_data});
              if (byte_cnt == 3'd3 && cmd_ok) begin
                if (opcode == OP_READ) begin
                  rd_ptr    <= rd_addr_c + 1'b1;
                  load_pend <= 1'b1;
                end
                if (opcode == OP_PP) pp_idx <= byte_data[PAGE_W-1:0];
              end
            end else if (cmd_ok) begin
              if (opcode == OP_READ) begin
                rd_ptr    <= rd_ptr + 1'b1;
                load_pend <= 1'b1;
              end
              if (opcode == OP_PP && !eng_busy) begin
                vld[pp_idx] <= 1'b1;
                pp_idx      <= pp_idx + 1'b1;
                pp_any      <= 1'b1;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/sfm_chk.sv
module sfm_chk (
  input logic clk,
  input logic rst,
  input logic cs_act,
  input logic cs_rise,
  input logic sck_fall,
  input logic miso,
  input logic busy,
  input logic wel
);
  // R11
  busy_holds_wel_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> wel);

  // R9
  start_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wel));

  // R10
  start_at_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cs_rise));

  // R11
  clear_together_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel);

  // R12
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !miso);

  // R12
  miso_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(miso) |-> $past(sck_fall || !cs_act));
endmodule

bind spi_flash_model sfm_chk chk_i (
  .clk(clk), .rst(rst), .cs_act(cs_act), .cs_rise(cs_rise),
  .sck_fall(sck_fall), .miso(spi_miso), .busy(eng_busy), .wel(wel)
);

// File: tb/spi_flash_model_tb_top.sv
module spi_flash_model_tb_top;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;
  logic mode3 = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] pb [8];
  logic [7:0] rb [8];

  always #5 clk = ~clk;

  spi_flash_model dut_i (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sel_on();
    sck = mode3;
    wait_half();
    cs_n = 1'b0;
    wait_half();
  endtask

  task automatic sel_off();
    if (!mode3) begin
      sck = 1'b0;
      wait_half();
    end
    cs_n = 1'b1;
    wait_half();
    wait_half();
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      if (sck) sck = 1'b0;
      mosi = tx[7-i];
      wait_half();
      rx = {rx[6:0], miso};
      sck = 1'b1;
      wait_half();
    end
  endtask

  task automatic xb(input logic [7:0] tx);
    logic [7:0] d;
    bits(tx, 8, d);
  endtask

  task automatic rd_status(output logic [7:0] s);
    sel_on();
    xb(8'h05);
    bits(8'h00, 8, s);
    sel_off();
  endtask

  task automatic wren();
    sel_on();
    xb(8'h06);
    sel_off();
  endtask

  task automatic send_addr(input logic [23:0] a);
    xb(a[23:16]);
    xb(a[15:8]);
    xb(a[7:0]);
  endtask

  task automatic pp(input logic [23:0] a, input int n);
    sel_on();
    xb(8'h02);
    send_addr(a);
    for (int i = 0; i < n; i++) xb(pb[i]);
    sel_off();
  endtask

  task automatic se(input logic [23:0] a);
    sel_on();
    xb(8'h20);
    send_addr(a);
    sel_off();
  endtask

  task automatic rd(input logic [23:0] a, input int n);
    sel_on();
    xb(8'h03);
    send_addr(a);
    for (int i = 0; i < n; i++) bits(8'h00, 8, rb[i]);
    sel_off();
  endtask

  task automatic wait_ready(input string req);
    logic [7:0] s;
    s = 8'h01;
    for (int i = 0; i < 60; i++) begin
      rd_status(s);
      if (!s[0]) break;
    end
    check(req, s, 8'h00);
  endtask

  task automatic pp1(input logic [23:0] a, input logic [7:0] d);
    wren();
    pb[0] = d;
    pp(a, 1);
    wait_ready("R11 ready after program");
  endtask

  task automatic t_reset();
    logic [7:0] s;
    check("R1 miso after reset", {7'b0, miso}, 8'h00);
    rd_status(s);
    check("R1 R4 status after reset", s, 8'h00);
  endtask

  task automatic t_abort();
    logic [7:0] s, d;
    sel_on();
    bits(8'h06, 5, d);
    sel_off();
    rd_status(s);
    check("R10 partial byte ignored", s, 8'h00);
    sel_on();
    xb(8'h06);
    xb(8'h00);
    sel_off();
    rd_status(s);
    check("R3 two-byte enable ignored", s, 8'h00);
  endtask

  task automatic t_no_wel_pp();
    logic [7:0] s;
    pb[0] = 8'h00;
    pp(24'h000100, 1);
    rd_status(s);
    check("R9 program without latch status", s, 8'h00);
    rd(24'h000100, 1);
    check("R9 program without latch data", rb[0], 8'hFF);
  endtask

  task automatic t_modes();
    logic [7:0] s;
    mode3 = 1'b1;
    wren();
    sel_on();
    xb(8'h05);
    bits(8'h00, 8, s);
    check("R2 R3 status in idle-high mode", s, 8'h02);
    bits(8'h00, 8, s);
    check("R4 status repeats", s, 8'h02);
    sel_off();
    mode3 = 1'b0;
    rd_status(s);
    check("R2 status in idle-low mode", s, 8'h02);
  endtask

  task automatic t_program();
    logic [7:0] s;
    pb[0] = 8'hA5;
    pb[1] = 8'h3C;
    pp(24'h000105, 2);
    rd_status(s);
    check("R11 status while busy", s, 8'h03);
    rd(24'h000105, 1);
    check("R11 read ignored while busy", rb[0], 8'h00);
    wait_ready("R11 bits clear after busy");
    rd(24'h000104, 4);
    check("R5 R6 byte 104", rb[0], 8'hFF);
    check("R6 byte 105", rb[1], 8'hA5);
    check("R6 byte 106", rb[2], 8'h3C);
    check("R6 byte 107", rb[3], 8'hFF);
  endtask

  task automatic t_and();
    pp1(24'h000105, 8'h0F);
    rd(24'h000105, 1);
    check("R6 program ANDs old data", rb[0], 8'h05);
  endtask

  task automatic t_wrap();
    wren();
    pb[0] = 8'h11;
    pb[1] = 8'h22;
    pb[2] = 8'h33;
    pp(24'h0002FE, 3);
    wait_ready("R11 ready after wrap program");
    rd(24'h0002FD, 4);
    check("R7 byte 2FD", rb[0], 8'hFF);
    check("R7 byte 2FE", rb[1], 8'h11);
    check("R7 byte 2FF", rb[2], 8'h22);
    check("R7 next page untouched", rb[3], 8'hFF);
    rd(24'h000200, 1);
    check("R7 wrapped to page start", rb[0], 8'h33);
  endtask

  task automatic t_erase();
    pp1(24'h0003FF, 8'h12);
    pp1(24'h000400, 8'h34);
    pp1(24'h0007FF, 8'h56);
    pp1(24'h000800, 8'h78);
    rd(24'h0003FF, 2);
    check("R8 planted 3FF", rb[0], 8'h12);
    check("R8 planted 400", rb[1], 8'h34);
    wren();
    se(24'h0005AB);
    wait_ready("R11 ready after erase");
    rd(24'h0003FF, 2);
    check("R8 lower neighbour kept", rb[0], 8'h12);
    check("R8 sector start erased", rb[1], 8'hFF);
    rd(24'h0007FF, 2);
    check("R8 sector end erased", rb[0], 8'hFF);
    check("R8 upper neighbour kept", rb[1], 8'h78);
  endtask

  task automatic t_read_wrap();
    pp1(24'h000FFF, 8'h77);
    pp1(24'h000000, 8'h66);
    rd(24'h000FFF, 3);
    check("R5 last byte", rb[0], 8'h77);
    check("R5 wraps to zero", rb[1], 8'h66);
    check("R5 byte one", rb[2], 8'hFF);
  endtask

  task automatic t_no_wel_se();
    logic [7:0] s;
    se(24'h000100);
    rd_status(s);
    check("R9 erase without latch status", s, 8'h00);
    rd(24'h000105, 1);
    check("R9 erase without latch data", rb[0], 8'h05);
    check("R12 miso low when deselected", {7'b0, miso}, 8'h00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_abort();
    t_no_wel_pp();
    t_modes();
    t_program();
    t_and();
    t_wrap();
    t_erase();
    t_read_wrap();
    t_no_wel_se();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule